// File: doc/BRIEF.md
# Interrupt priority and mask arbiter

This block sits between the interrupt sources of a small controller and its CPU core. Each cycle it looks at the pending flags of the non-maskable input, a row of general requests and two keyboard-group requests. It applies the mask rules of the selected control mode and picks a single winner. The winner's vector number is registered and presented together with a request line. The vector is held until the CPU returns a one-cycle acknowledge, and only then is a fresh choice made. Clearing the source flag is left to the source logic.

Two control modes exist. The simple mode uses one CPU mask bit as a global gate. The priority mode combines two CPU mask bits with a one-bit priority per source, which gives three mask levels. A map-select input decides how the two keyboard groups are numbered. In the shared map they fold into general requests 6 and 7. In the split map each group gets a vector of its own, placed just above the general requests.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `irq_o` is 0 and `vec_o` is 0.
- R2: A pending `nmi_i` wins over every other source whatever the masks and mode, and gives vector `VEC_NMI` (7).
- R3: Any `mode_i` other than 2'b10 selects the simple mode. In that mode, `mask_i`=1 blocks every maskable source, the priority bits are ignored, and `mask_u_i` has no effect.
- R4: In the priority mode (`mode_i`=2'b10) with `mask_i`=0, every pending source is admitted, and any pending priority-1 source beats every priority-0 source regardless of vector number.
- R5: In the priority mode with `mask_i`=1 and `mask_u_i`=0, only sources whose priority bit is 1 are admitted.
- R6: In the priority mode with `mask_i`=1 and `mask_u_i`=1, no maskable source is admitted.
- R7: Among admitted sources of equal priority, the lowest vector number wins. General request i has vector `VEC_BASE`+i (base 16).
- R8: With `ext_map_i`=0, keyboard group 0 (`kbd_pend_i[0]`) raises the vector of general request 6 (22) and group 1 raises that of request 7 (23). Both use `prio_i[6]` and `prio_i[7]` respectively, and `kbd_prio_i` is ignored.
- R9: With `ext_map_i`=1, keyboard group 0 gets vector `VEC_BASE`+`N_SRC` (32) and group 1 gets `VEC_BASE`+`N_SRC`+1 (33), with priorities `kbd_prio_i[0]` and `kbd_prio_i[1]`.
- R10: While idle, an admitted source makes `irq_o` rise and `vec_o` take the winner on the clock edge after it appears. `vec_o` and `irq_o` then stay unchanged until acknowledge, even if the inputs change.
- R11: `irq_o` falls on the edge that samples `ack_i`=1, and a new choice is made on the next edge. `ack_i` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable request pending |
| pend_i | input | N_SRC | General request pending flags |
| prio_i | input | N_SRC | Per-source priority bit |
| kbd_pend_i | input | 2 | Keyboard group pending flags |
| kbd_prio_i | input | 2 | Keyboard group priority, split map only |
| mode_i | input | 2 | Control mode, 2'b10 = priority mode |
| mask_i | input | 1 | CPU mask bit |
| mask_u_i | input | 1 | Second CPU mask bit, priority mode only |
| ext_map_i | input | 1 | 1 = split keyboard vectors |
| ack_i | input | 1 | One-cycle acknowledge from CPU |
| irq_o | output | 1 | Request to CPU |
| vec_o | output | VEC_W | Vector number of the held request |

## Verification
The bench runs the three mask levels against sources that have mixed priority bits. A design that compared vector numbers before priority would give a low-numbered priority-0 source in R4. A design that decoded the two reserved mode values as the priority mode would let masked requests through. Both keyboard groups are run under each map. The priority mode is included there, so that the wrong priority bit for a folded group blocks the request. The hold test changes the inputs and raises the non-maskable input while a request waits. A design that re-arbitrates on each cycle would then change `vec_o` before acknowledge. An acknowledge sent while idle must not disturb the next request.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC    = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int VEC_NMI  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic [1:0]       kbd_pend_i,
  input  logic [1:0]       kbd_prio_i,
  input  logic [1:0]       mode_i,
  input  logic             mask_i,
  input  logic             mask_u_i,
  input  logic             ext_map_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int M     = N_SRC + 2;
  localparam int IDX_W = $clog2(M);

  logic [M-1:0]     eff_pend, eff_prio, adm, hi_set, pick;
  logic [IDX_W-1:0] sel;
  logic             prio_mode, ok_lo, ok_hi, cand;
  logic [VEC_W-1:0] choice;

  assign prio_mode = (mode_i == 2'b10);
  assign ok_lo     = !mask_i;
  assign ok_hi     = prio_mode ? !(mask_i && mask_u_i) : !mask_i;

  always_comb begin
    eff_pend = {kbd_pend_i, pend_i};
    eff_prio = {kbd_prio_i, prio_i};
    if (!ext_map_i) begin
      eff_pend[6]     = pend_i[6] | kbd_pend_i[0];
      eff_pend[7]     = pend_i[7] | kbd_pend_i[1];
      eff_pend[M-1:N_SRC] = 2'b00;
    end
    if (!prio_mode) eff_prio = '0;
  end

  always_comb begin
    for (int i = 0; i < M; i++)
      adm[i] = eff_pend[i] && (eff_prio[i] ? ok_hi : ok_lo);
  end

  assign hi_set = adm & eff_prio;
  assign pick   = (|hi_set) ? hi_set : adm;

  always_comb begin
    sel = '0;
    for (int i = M - 1; i >= 0; i--)
      if (pick[i]) sel = IDX_W'(i);
  end

  assign cand   = nmi_i || (|adm);
  assign choice = nmi_i ? VEC_W'(VEC_NMI) : VEC_W'(VEC_BASE) + VEC_W'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else if (irq_o) begin
      if (ack_i) irq_o <= 1'b0;
    end else if (cand) begin
      irq_o <= 1'b1;
      vec_o <= choice;
    end
  end

  assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && nmi_i) |=> (irq_o && vec_o == VEC_W'(VEC_NMI)));

  assert_simple_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !nmi_i && mode_i != 2'b10 && mask_i) |=> !irq_o);

  assert_full_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !nmi_i && mode_i == 2'b10 && mask_i && mask_u_i) |=> !irq_o);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  assert_ack_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i) |=> !irq_o);

  assert_idle_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !cand) |=> (!irq_o && $stable(vec_o)));
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  localparam int CLK_P = 10;
  localparam int NROW  = 18;

  typedef struct packed {
    logic        nmi;
    logic [1:0]  mode;
    logic        mi;
    logic        mu;
    logic        ext;
    logic [15:0] pend;
    logic [15:0] prio;
    logic [1:0]  kbd;
    logic [1:0]  kbdp;
    logic        irq;
    logic [7:0]  vec;
  } row_t;

  localparam row_t TBL [NROW] = '{
    '{1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'b00, 2'b00, 1'b1, 8'd7},
    '{1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 16'hffff, 16'hffff, 2'b11, 2'b11, 1'b1, 8'd7},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0030, 16'h0020, 2'b00, 2'b00, 1'b1, 8'd20},
    '{1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 16'hffff, 16'hffff, 2'b11, 2'b11, 1'b0, 8'd0},
    '{1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 16'hffff, 16'hffff, 2'b00, 2'b00, 1'b0, 8'd0},
    '{1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 16'h0100, 16'h0000, 2'b00, 2'b00, 1'b1, 8'd24},
    '{1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 16'h0006, 16'h0004, 2'b00, 2'b00, 1'b1, 8'd18},
    '{1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 16'h8001, 16'h0000, 2'b00, 2'b00, 1'b1, 8'd16},
    '{1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 16'h0003, 16'h0000, 2'b00, 2'b00, 1'b0, 8'd0},
    '{1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 16'h0c01, 16'h0c00, 2'b00, 2'b00, 1'b1, 8'd26},
    '{1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 16'hffff, 16'hffff, 2'b11, 2'b11, 1'b0, 8'd0},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'b01, 2'b00, 1'b1, 8'd22},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'b10, 2'b00, 1'b1, 8'd23},
    '{1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0040, 2'b01, 2'b00, 1'b1, 8'd22},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 2'b01, 2'b00, 1'b1, 8'd32},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 2'b10, 2'b00, 1'b1, 8'd33},
    '{1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0040, 2'b11, 2'b10, 1'b1, 8'd33},
    '{1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 16'h0040, 16'h0000, 2'b01, 2'b00, 1'b1, 8'd22}
  };

  // row requirements: R2 R2 R3 R3 R3 R3 R4 R4/R7 R5 R5/R7 R6 R8 R8 R8 R9 R9 R9 R9/R7
  localparam string RQ [NROW] = '{"R2","R2","R3","R3","R3","R3","R4","R7","R5","R7",
                                  "R6","R8","R8","R8","R9","R9","R9","R9"};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        nmi_i = 1'b0, mask_i = 1'b0, mask_u_i = 1'b0, ext_map_i = 1'b0, ack_i = 1'b0;
  logic [15:0] pend_i = '0, prio_i = '0;
  logic [1:0]  kbd_pend_i = '0, kbd_prio_i = '0, mode_i = '0;
  logic        irq_o;
  logic [7:0]  vec_o;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .pend_i(pend_i), .prio_i(prio_i),
    .kbd_pend_i(kbd_pend_i), .kbd_prio_i(kbd_prio_i), .mode_i(mode_i),
    .mask_i(mask_i), .mask_u_i(mask_u_i), .ext_map_i(ext_map_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clear_in();
    nmi_i = 0; mode_i = 0; mask_i = 0; mask_u_i = 0; ext_map_i = 0;
    pend_i = 0; prio_i = 0; kbd_pend_i = 0; kbd_prio_i = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", irq_o, 0);
    chk("R1", vec_o, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      nmi_i = TBL[r].nmi; mode_i = TBL[r].mode; mask_i = TBL[r].mi; mask_u_i = TBL[r].mu;
      ext_map_i = TBL[r].ext; pend_i = TBL[r].pend; prio_i = TBL[r].prio;
      kbd_pend_i = TBL[r].kbd; kbd_prio_i = TBL[r].kbdp;
      @(posedge clk); #1;
      chk(RQ[r], irq_o, TBL[r].irq);
      if (TBL[r].irq) chk(RQ[r], vec_o, TBL[r].vec);
      @(negedge clk); ack_i = 1'b1; clear_in();
      @(negedge clk); ack_i = 1'b0;
      @(posedge clk); #1;
      chk("R11", irq_o, 0);
    end

    // R10: request latched one edge later, held while inputs change
    @(negedge clk); pend_i = 16'h0020;
    #1 chk("R10", irq_o, 0);
    @(posedge clk); #1;
    chk("R10", irq_o, 1);
    chk("R10", vec_o, 21);
    @(negedge clk); pend_i = 16'h0001; nmi_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", irq_o, 1);
    chk("R10", vec_o, 21);
    // R11: ack drops request, next edge re-arbitrates to NMI
    @(negedge clk); ack_i = 1'b1;
    @(posedge clk); #1;
    chk("R11", irq_o, 0);
    @(negedge clk); ack_i = 1'b0;
    @(posedge clk); #1;
    chk("R11", irq_o, 1);
    chk("R2", vec_o, 7);
    @(negedge clk); ack_i = 1'b1; clear_in();
    @(negedge clk); ack_i = 1'b0;
    // R11: ack while idle ignored
    @(negedge clk); ack_i = 1'b1;
    @(posedge clk); #1;
    chk("R11", irq_o, 0);
    @(negedge clk); ack_i = 1'b0; pend_i = 16'h0004;
    @(posedge clk); #1;
    chk("R11", irq_o, 1);
    chk("R11", vec_o, 18);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule